// File: doc/BRIEF.md
# Round-and-Saturate Fixed-Point Narrower

This block takes a wide signed two's-complement result, typically a product or an accumulated sum, and brings it back to a 24-bit word. The output word has 18 fractional bits and 6 integer bits, with the top bit as the sign. The input carries the same binary point plus `DROP_F` extra fractional bits below it, and any number of extra integer bits above it.

The surplus fractional bits are removed first. A rounding carry is added to the truncated value, and the rule for that carry depends on the sign. The word is widened by one sign bit before the carry goes in. The surplus integer bits are then checked against the sign of the narrowed word. When they are only copies of that sign, they are dropped. Otherwise the output is forced to the most positive or most negative code and a flag is raised.

The block sits at the end of a multiply or sum stage in an iterated fixed-point datapath. It can run as a pure combinational path, or as a path with one output register.

Top module: `fxn_narrow`

## Requirements
- R1: The parameters `IN_W` and `DROP_F` set the input width and the number of fractional bits removed. The input is read as two's complement with 18 + `DROP_F` fractional bits. The output is 24-bit two's complement with 18 fractional bits.
- R2: For an input with sign bit 0, the truncated value is incremented when the most significant dropped bit is 1. An exact half therefore moves up, to the larger code.
- R3: For an input with sign bit 1, the truncated value is incremented only when the most significant dropped bit is 1 and at least one lower dropped bit is also 1. An exact half stays at the lower, more negative code.
- R4: The truncated value is widened by one sign bit before the carry is added. A carry on the largest positive truncated value therefore never wraps; that result is treated as out of range.
- R5: When every bit of the rounded value above bit 23 equals bit 23, the output is the low 24 bits of the rounded value and `sat` is 0.
- R6: Otherwise a non-negative rounded value gives 0x7FFFFF and a negative one gives 0x800000.
- R7: `sat` is 1 exactly when the output was clamped by R6.
- R8: With `REG_OUT`=1, `out_vld`, `dout` and `sat` appear one clock after the input is presented with `in_vld`=1. When `in_vld` is 0, `dout` and `sat` hold their values. Synchronous active-high reset clears all three outputs to 0.
- R9: With `REG_OUT`=0 the path is combinational, and `out_vld` follows `in_vld` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only when `REG_OUT`=1 |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input word is valid |
| din | input | IN_W | Wide signed input value |
| out_vld | output | 1 | Output word is valid |
| dout | output | 24 | Narrowed, rounded and clamped value |
| sat | output | 1 | Output was clamped to a limit code |

## Verification
The bench builds two copies of the block.

The first uses the defaults: a 48-bit input, 18 dropped bits and a registered output. This matches the width of a product of two 24-bit words. It reaches the exact-half cases of both signs, carries that push the top code out of range, and inputs just below the most negative code that round back into range.

The second is combinational, with a 30-bit input and a single dropped bit. With only one dropped bit there are no lower dropped bits, so a negative value can never take a carry. This copy exercises that degenerate branch of the negative rounding rule together with a narrower integer surplus.

// File: rtl/fxn_pkg.sv
package fxn_pkg;

    localparam int OUT_W = 24;
    localparam int OUT_F = 18;

    localparam logic [OUT_W-1:0] POS_LIMIT = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] NEG_LIMIT = {1'b1, {(OUT_W-1){1'b0}}};

    typedef struct packed {
        logic             sat;
        logic [OUT_W-1:0] val;
    } narrow_t;

    // sign-dependent carry: negative halves do not move up
    function automatic logic round_carry(logic neg, logic top_drop, logic rest_any);
        return neg ? (top_drop & rest_any) : top_drop;
    endfunction

    function automatic narrow_t limit_word(logic neg);
        narrow_t r;
        r.sat = 1'b1;
        r.val = neg ? NEG_LIMIT : POS_LIMIT;
        return r;
    endfunction

endpackage

// File: rtl/fxn_round.sv
module fxn_round
    import fxn_pkg::*;
#(
    parameter int IN_W   = 48,
    parameter int DROP_F = 18,
    localparam int MID_W = IN_W - DROP_F + 1
) (
    input  logic [IN_W-1:0]  din,
    output logic [MID_W-1:0] rounded
);

    logic             neg;
    logic             top_drop;
    logic             rest_any;
    logic             carry;
    logic [MID_W-1:0] ext;

    assign neg      = din[IN_W-1];
    assign top_drop = din[DROP_F-1];

    generate
        if (DROP_F == 1) begin : g_single
            assign rest_any = 1'b0;
        end else begin : g_multi
            assign rest_any = |din[DROP_F-2:0];
        end
    endgenerate

    assign carry   = round_carry(neg, top_drop, rest_any);
    assign ext     = {din[IN_W-1], din[IN_W-1:DROP_F]};
    assign rounded = ext + {{(MID_W-1){1'b0}}, carry};

endmodule

// File: rtl/fxn_clamp.sv
module fxn_clamp
    import fxn_pkg::*;
#(
    parameter int MID_W = 31,
    localparam int UP_W = MID_W - OUT_W + 1
) (
    input  logic [MID_W-1:0] rounded,
    output narrow_t          res
);

    logic [UP_W-1:0] upper;
    logic            fits;

    assign upper = rounded[MID_W-1:OUT_W-1];
    assign fits  = (&upper) | ~(|upper);

    always_comb begin
        if (fits) begin
            res.sat = 1'b0;
            res.val = rounded[OUT_W-1:0];
        end else begin
            res = limit_word(rounded[MID_W-1]);
        end
    end

endmodule

// File: rtl/fxn_narrow.sv
module fxn_narrow
    import fxn_pkg::*;
#(
    parameter int IN_W    = 48,
    parameter int DROP_F  = 18,
    parameter bit REG_OUT = 1'b1,
    localparam int MID_W  = IN_W - DROP_F + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_vld,
    input  logic [IN_W-1:0]  din,
    output logic             out_vld,
    output logic [OUT_W-1:0] dout,
    output logic             sat
);

    logic [MID_W-1:0] rounded;
    narrow_t          res;

    fxn_round #(.IN_W(IN_W), .DROP_F(DROP_F)) u_round (
        .din     (din),
        .rounded (rounded)
    );

    fxn_clamp #(.MID_W(MID_W)) u_clamp (
        .rounded (rounded),
        .res     (res)
    );

    generate
        if (REG_OUT) begin : g_reg
            narrow_t res_q;
            logic    vld_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    res_q <= '0;
                    vld_q <= 1'b0;
                end else begin
                    vld_q <= in_vld;
                    if (in_vld) res_q <= res;
                end
            end
            assign out_vld = vld_q;
            assign dout    = res_q.val;
            assign sat     = res_q.sat;
        end else begin : g_comb
            assign out_vld = in_vld;
            assign dout    = res.val;
            assign sat     = res.sat;
        end
    endgenerate

endmodule

// File: rtl/fxn_narrow_chk.sv
module fxn_narrow_chk
    import fxn_pkg::*;
#(
    parameter int IN_W    = 48,
    parameter int DROP_F  = 18,
    parameter bit REG_OUT = 1'b1
) (
    input logic             clk,
    input logic             rst,
    input logic             in_vld,
    input logic [IN_W-1:0]  din,
    input logic             out_vld,
    input logic [OUT_W-1:0] dout,
    input logic             sat
);

    // R7
    sat_code_chk: assert property (@(posedge clk) disable iff (rst)
        (out_vld && sat) |-> (dout == POS_LIMIT || dout == NEG_LIMIT));

    generate
        if (REG_OUT) begin : g_seq
            // R6
            neg_limit_chk: assert property (@(posedge clk) disable iff (rst)
                (in_vld && din[IN_W-1]) |=> (!sat || dout == NEG_LIMIT));
            // R2
            pos_sign_chk: assert property (@(posedge clk) disable iff (rst)
                (in_vld && !din[IN_W-1]) |=> (sat || !dout[OUT_W-1]));
            // R8
            vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
                in_vld |=> out_vld);
            // R8
            hold_out_chk: assert property (@(posedge clk) disable iff (rst)
                !in_vld |=> (!out_vld && $stable(dout) && $stable(sat)));
        end else begin : g_cmb
            // R6
            neg_limit_chk: assert property (@(posedge clk) disable iff (rst)
                (in_vld && din[IN_W-1]) |-> (!sat || dout == NEG_LIMIT));
            // R2
            pos_sign_chk: assert property (@(posedge clk) disable iff (rst)
                (in_vld && !din[IN_W-1]) |-> (sat || !dout[OUT_W-1]));
            // R3
            neg_sign_chk: assert property (@(posedge clk) disable iff (rst)
                (in_vld && din[IN_W-1] && !sat) |-> (dout[OUT_W-1] || dout == '0));
        end
    endgenerate

endmodule

bind fxn_narrow fxn_narrow_chk #(
    .IN_W(IN_W), .DROP_F(DROP_F), .REG_OUT(REG_OUT)
) u_chk (
    .clk(clk), .rst(rst), .in_vld(in_vld), .din(din),
    .out_vld(out_vld), .dout(dout), .sat(sat)
);

// File: tb/sim_fxn_narrow.sv
module sim_fxn_narrow;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_vld;
    logic [47:0] din0;
    logic [29:0] din1;
    logic        o0_vld, o0_sat, o1_vld, o1_sat;
    logic [23:0] o0_val, o1_val;

    int checks = 0;
    int errors = 0;

    longint m_val;
    bit     m_sat;
    bit     m_vld;
    string  m_tag;

    always #10 clk = ~clk;

    fxn_narrow #(.IN_W(48), .DROP_F(18), .REG_OUT(1'b1)) u0 (
        .clk(clk), .rst(rst), .in_vld(in_vld), .din(din0),
        .out_vld(o0_vld), .dout(o0_val), .sat(o0_sat)
    );

    fxn_narrow #(.IN_W(30), .DROP_F(1), .REG_OUT(1'b0)) u1 (
        .clk(clk), .rst(rst), .in_vld(in_vld), .din(din1),
        .out_vld(o1_vld), .dout(o1_val), .sat(o1_sat)
    );

    function automatic longint sext(longint x, int w);
        return (x <<< (64 - w)) >>> (64 - w);
    endfunction

    // behavioural reference: nearest code, ties away from zero, then clamp
    function automatic longint ref_val(longint x, int d, output bit s, output string tag);
        longint q, rem, half, r;
        q    = x >>> d;
        rem  = x - (q <<< d);
        half = longint'(1) <<< (d - 1);
        if (x >= 0) r = q + ((rem >= half) ? 1 : 0);
        else        r = q + ((rem >  half) ? 1 : 0);
        s = 1'b0;
        if (x >= 0 && rem >= half) tag = "R2";
        else if (x < 0 && rem >= half) tag = "R3";
        else tag = "R5";
        if (r > 8388607) begin
            tag = (q == 8388607) ? "R4" : "R6";
            r = 8388607; s = 1'b1;
        end else if (r < -8388608) begin
            tag = "R6";
            r = -8388608; s = 1'b1;
        end
        return r & 64'hFFFFFF;
    endfunction

    task automatic chk(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(bit v, longint raw);
        longint x0, x1, e1;
        bit     s1;
        string  t1;
        // registered copy: result of the previous step (or held value)
        chk("R8", longint'(o0_vld), longint'(m_vld));
        chk(m_tag, longint'(o0_val), m_val);
        chk("R7", longint'(o0_sat), longint'(m_sat));
        x0 = sext(raw, 48);
        x1 = sext(raw, 30);
        in_vld = v;
        din0   = x0[47:0];
        din1   = x1[29:0];
        m_vld  = v;
        if (v) m_val = ref_val(x0, 18, m_sat, m_tag);
        #1;
        // combinational copy: same cycle
        chk("R9", longint'(o1_vld), longint'(v));
        if (v) begin
            e1 = ref_val(x1, 1, s1, t1);
            chk({"R1/", t1}, longint'(o1_val), e1);
            chk("R7", longint'(o1_sat), longint'(s1));
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        longint r;
        rst = 1'b1; in_vld = 1'b0; din0 = '0; din1 = '0;
        m_val = 0; m_sat = 1'b0; m_vld = 1'b0; m_tag = "R8";
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // reset state is checked by the first step (R8)
        step(1'b1, 64'sd0);
        step(1'b1, 64'sh20000);                       // R2 positive half
        step(1'b1, -64'sh20000);                      // R3 negative half stays
        step(1'b1, -64'sh20001);                      // R3
        step(1'b1, -64'sh1FFFF);                      // R3 rounds up to 0
        step(1'b1, -64'sd1);                          // all ones -> 0
        step(1'b1, 64'sh1FFFF);
        step(1'b1, (64'sh7FFFFF <<< 18) | 64'sh20000); // R4 carry out of range
        step(1'b1, (64'sh7FFFFF <<< 18) | 64'sh1FFFF); // R5 top code
        step(1'b1, -(64'sh800000 <<< 18));            // R5 bottom code
        step(1'b1, -(64'sh800000 <<< 18) - 1);        // rounds back in
        step(1'b1, -(64'sh800000 <<< 18) - 64'sh20000); // R6 negative clamp
        step(1'b1, 64'sh7FFFFFFFFFFF);                // R6 positive clamp
        step(1'b1, -64'sh800000000000);               // R6 negative clamp
        step(1'b0, 64'sh123456789AB);                 // R8 hold
        step(1'b0, -64'sh5);                          // R8 hold
        step(1'b1, 64'sh3);
        for (int i = 0; i < 3000; i++) begin
            r = {$urandom, $urandom};
            r = r >>> ($urandom % 44);
            if (($urandom % 4) == 0) r = (r >>> 18) <<< 18 | (($urandom % 2) ? 64'sh20000 : 64'sh0);
            step(($urandom % 8) != 0, r);
        end
        step(1'b0, 64'sd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule